// File: doc/BRIEF.md
# Register-Indirect Accumulator Processor Core

This block is a small 16-bit processor core with a single accumulator. It fetches one-address instructions from a synchronous word-addressed memory and runs each through a fixed sequence of one-clock micro-steps. The core holds a program counter, a memory address register, a memory buffer register, an instruction register, the accumulator and a file of sixteen 16-bit general registers.

Memory operands are reached in two hops. The instruction names a general register, and that register holds a pointer into memory. The 12-bit operand field of the word found at the pointer overwrites the operand field of the instruction register. That field then addresses the final operand, which is loaded, combined with the accumulator or written from it. Two short register-side instructions set up pointers without touching memory: one loads a 12-bit constant into the accumulator, and one copies the accumulator into a general register.

The memory answers a read one clock after the read strobe and takes a write at the clock edge where the write strobe is high. The address is valid in the same cycle as either strobe.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the accumulator and all sixteen general registers. In the first cycle after release the core drives a read at address 0 with `halted` low.
- R2: An instruction word carries its opcode in bits 15:12 and its operand field in bits 11:0, and bits 3:0 select a general register. Every instruction begins with a read at the program counter. Opcode 0 (no-op) takes three cycles, so back-to-back no-ops fetch addresses 0, 1, 2, ... one every third cycle.
- R3: Opcode 8 loads the accumulator with bits 11:0 of the instruction, zero-extended, and takes three cycles.
- R4: Opcode 9 copies the accumulator into the general register selected by bits 3:0 and takes three cycles.
- R5: Opcodes 1 to 6 take nine cycles. Cycle 4 reads at the address held in the selected register. Bits 11:0 of that word replace the instruction's operand field, and cycle 7 reads at that field, zero-extended. The next fetch starts in cycle 10.
- R6: Opcode 1 (load) places the word from the final read into the accumulator.
- R7: Opcode 2 adds the final word to the accumulator, and opcode 3 subtracts it from the accumulator, both modulo 2^16.
- R8: Opcode 4 takes the bitwise AND, and opcode 5 the bitwise OR, of the accumulator and the final word.
- R9: Opcode 6 (store) makes no read in cycle 7. In cycle 9 it raises the write strobe at the final address, with the accumulator on the write data.
- R10: Opcode 7 (halt) raises `halted` in the cycle after its third cycle. From then on the core drives no read or write strobe until reset.
- R11: Opcodes 10 to 15 behave as opcode 0: three cycles and no change to the accumulator.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address, valid with either strobe |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one clock later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest case to reach from the ports is the double hop through memory. A wrong register select, a pointer word whose upper bits leak into the final address, or an operand field that is not overwritten only shows up when the pointer word, the final operand and the instruction stream are all set up consistently. Each bench program therefore first builds pointers with the constant-load and register-copy instructions. It then places pointer words whose upper bits are junk next to distinct data words. Each result is stored back to memory through a second pointer, and the bench checks that value together with the cycle-exact strobe trace. Sweeps run every register index and a set of edge operand pairs for each arithmetic and logic operation.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_ADD   = 4'h2,
        OP_SUB   = 4'h3,
        OP_AND   = 4'h4,
        OP_OR    = 4'h5,
        OP_STORE = 4'h6,
        OP_HALT  = 4'h7,
        OP_LDI   = 4'h8,
        OP_PUT   = 4'h9
    } opcode_e;

    typedef enum logic [3:0] {
        S_T1, S_T2, S_T3, S_T4, S_T5, S_T6, S_T7, S_T8, S_T9, S_HALT
    } step_e;

    function automatic logic is_mem_op(input logic [OPC_W-1:0] opc);
        return (opc >= OP_LOAD) && (opc <= OP_STORE);
    endfunction

endpackage

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [NREG-1:0][DATA_W-1:0] file_q;

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [DATA_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (widx == IDX_W'(g))) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign file_q[g] = ent_q;
    end

    assign rdata = file_q[ridx];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted,
    output logic [IDX_W-1:0]  rf_ridx,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_widx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [OPC_W-1:0]  alu_op,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    input  logic [DATA_W-1:0] alu_y,
    output step_e             step_o,
    output logic [DATA_W-1:0] pc_o
);

    localparam int AF_W = DATA_W - OPC_W;

    typedef struct packed {
        step_e             step;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
    } core_st_t;

    core_st_t q, d;

    logic [OPC_W-1:0] opc_ir, opc_mbr;
    logic             is_store;

    assign opc_ir   = q.ir[DATA_W-1 -: OPC_W];
    assign opc_mbr  = q.mbr[DATA_W-1 -: OPC_W];
    assign is_store = (opc_ir == OP_STORE);

    always_comb begin
        d        = q;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        rf_we    = 1'b0;
        unique case (q.step)
            S_T1: begin
                d.mar  = q.pc;
                mem_rd = 1'b1;
                d.step = S_T2;
            end
            S_T2: begin
                d.mbr  = mem_rdata;
                d.pc   = q.pc + DATA_W'(1);
                d.step = S_T3;
            end
            S_T3: begin
                d.ir = q.mbr;
                if (opc_mbr == OP_LDI) begin
                    d.acc  = {{OPC_W{1'b0}}, q.mbr[AF_W-1:0]};
                    d.step = S_T1;
                end else if (opc_mbr == OP_PUT) begin
                    rf_we  = 1'b1;
                    d.step = S_T1;
                end else if (opc_mbr == OP_HALT) begin
                    d.step = S_HALT;
                end else if (is_mem_op(opc_mbr)) begin
                    d.step = S_T4;
                end else begin
                    d.step = S_T1;
                end
            end
            S_T4: begin
                d.mar  = rf_rdata;
                mem_rd = 1'b1;
                d.step = S_T5;
            end
            S_T5: begin
                d.mbr  = mem_rdata;
                d.step = S_T6;
            end
            S_T6: begin
                d.ir[AF_W-1:0] = q.mbr[AF_W-1:0];
                d.step         = S_T7;
            end
            S_T7: begin
                d.mar  = {{OPC_W{1'b0}}, q.ir[AF_W-1:0]};
                mem_rd = !is_store;
                d.step = S_T8;
            end
            S_T8: begin
                if (!is_store) begin
                    d.mbr = mem_rdata;
                end
                d.step = S_T9;
            end
            S_T9: begin
                if (is_store) begin
                    mem_wr = 1'b1;
                end else begin
                    d.acc = alu_y;
                end
                d.step = S_T1;
            end
            S_HALT: begin
                d.step = S_HALT;
            end
            default: begin
                d.step = S_T1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.step <= S_T1;
            q.pc   <= '0;
            q.mar  <= '0;
            q.mbr  <= '0;
            q.ir   <= '0;
            q.acc  <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = d.mar;
    assign mem_wdata = q.acc;
    assign halted    = (q.step == S_HALT);
    assign rf_ridx   = q.ir[IDX_W-1:0];
    assign rf_widx   = q.mbr[IDX_W-1:0];
    assign rf_wdata  = q.acc;
    assign alu_op    = opc_ir;
    assign alu_a     = q.acc;
    assign alu_b     = q.mbr;
    assign step_o    = q.step;
    assign pc_o      = q.pc;

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    localparam int IDX_W = $clog2(NREG);

    logic [IDX_W-1:0]  rf_ridx, rf_widx;
    logic [DATA_W-1:0] rf_rdata, rf_wdata;
    logic              rf_we;
    logic [OPC_W-1:0]  alu_op;
    logic [DATA_W-1:0] alu_a, alu_b, alu_y;
    step_e             step_w;
    logic [DATA_W-1:0] pc_w;

    acc_cpu_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .halted    (halted),
        .rf_ridx   (rf_ridx),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_widx   (rf_widx),
        .rf_wdata  (rf_wdata),
        .alu_op    (alu_op),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_y     (alu_y),
        .step_o    (step_w),
        .pc_o      (pc_w)
    );

    acc_cpu_regfile #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .widx  (rf_widx),
        .wdata (rf_wdata),
        .ridx  (rf_ridx),
        .rdata (rf_rdata)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op (alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_addr,
    input logic              halted,
    input step_e             step,
    input logic [DATA_W-1:0] pc
);

    // R12
    p_rw_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    // R10
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R1
    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_rd && (mem_addr == '0) && !halted));

    // R2
    p_pc_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (step == S_T2) |=> (pc == $past(pc) + DATA_W'(1)));

    // R5
    p_ptr_read_r5: assert property (@(posedge clk) disable iff (rst)
        (step == S_T4) |-> mem_rd);

    // R5
    p_chain_r5: assert property (@(posedge clk) disable iff (rst)
        (step == S_T6) |=> (step == S_T7));

    // R5
    p_return_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        (step == S_T9) |=> (step == S_T1 && mem_rd && mem_addr == pc));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .halted   (halted),
    .step     (step_w),
    .pc       (pc_w)
);

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halted;

    logic        ld_en = 1'b0;
    logic [15:0] ld_addr = '0, ld_data = '0;
    logic [15:0] mem [0:65535];

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    int          ev_n, halt_cyc, pp;
    int          ev_cyc [0:63];
    bit          ev_rd  [0:63];
    bit          ev_wr  [0:63];
    logic [15:0] ev_addr[0:63];
    logic [15:0] ev_dat [0:63];

    always #4 clk = ~clk;   // 8 ns period

    acc_cpu_core dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int ev_at(input int c);
        for (int i = 0; i < ev_n; i++) if (ev_cyc[i] == c) return i;
        return -1;
    endfunction

    task automatic chk_ev(input string req, input int c, input bit rd,
                          input bit wr, input logic [15:0] a);
        int i;
        logic [31:0] act;
        i = ev_at(c);
        act = (i < 0) ? 32'hDEAD0000 : {14'b0, ev_rd[i], ev_wr[i], ev_addr[i]};
        chk(req, act, {14'b0, rd, wr, a}, $sformatf("strobe at cycle %0d", c));
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] v);
        ld_en = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic prog_begin();
        @(negedge clk);
        rst = 1'b1;
        pp = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic emit(input logic [15:0] w);
        poke(16'(pp), w);
        pp++;
    endtask

    task automatic run_prog(input int maxc);
        ev_n = 0; halt_cyc = -1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", {mem_rd, halted, mem_addr}, {1'b1, 1'b0, 16'h0000}, "first cycle after reset");
        for (int c = 0; c < maxc; c++) begin
            if (halted && halt_cyc < 0) halt_cyc = c;
            if (halt_cyc >= 0 && c >= halt_cyc + 10) break;
            if ((mem_rd || mem_wr) && ev_n < 64) begin
                ev_cyc[ev_n] = c; ev_rd[ev_n] = mem_rd; ev_wr[ev_n] = mem_wr;
                ev_addr[ev_n] = mem_addr; ev_dat[ev_n] = mem_wdata;
                ev_n++;
            end
            @(negedge clk);
            #1;
        end
        if (halt_cyc < 0) chk("R10", 32'd0, 32'd1, "program reached halt");
    endtask

    function automatic logic [15:0] alu_ref(input int op, input logic [15:0] a,
                                            input logic [15:0] b);
        case (op)
            2: return a + b;
            3: return a - b;
            4: return a & b;
            default: return a | b;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] va [0:7];
        logic [15:0] vb [0:7];
        logic [11:0] kv [0:3];
        va[0] = 16'h0000; vb[0] = 16'h0000;
        va[1] = 16'hFFFF; vb[1] = 16'h0001;
        va[2] = 16'h8000; vb[2] = 16'h8000;
        va[3] = 16'h1234; vb[3] = 16'h4321;
        va[4] = 16'h0000; vb[4] = 16'h0001;
        va[5] = 16'hA5A5; vb[5] = 16'h5A5A;
        va[6] = 16'hFFFF; vb[6] = 16'hFFFF;
        va[7] = 16'h7FFF; vb[7] = 16'h0001;
        kv[0] = 12'h000; kv[1] = 12'hFFF; kv[2] = 12'hABC; kv[3] = 12'h5A5;

        // R2 / R11 / R10: no-ops, undefined opcodes, then halt
        prog_begin();
        emit(16'h0000); emit(16'hA123); emit(16'hB456); emit(16'hCFFF);
        emit(16'hD000); emit(16'hE001); emit(16'hF00F); emit(16'h0FFF);
        emit(16'h7000);
        run_prog(100);
        for (int k = 0; k < 9; k++) begin
            if (k >= 1 && k <= 6) chk_ev("R11", 3 * k, 1'b1, 1'b0, 16'(k));
            else chk_ev("R2", 3 * k, 1'b1, 1'b0, 16'(k));
        end
        chk("R2", ev_n, 9, "strobe count for no-op stream");
        chk("R10", halt_cyc, 27, "halt cycle");
        begin
            int late = 0;
            for (int i = 0; i < ev_n; i++) if (ev_cyc[i] >= 27) late++;
            chk("R10", late, 0, "strobes after halt");
        end

        // R5 / R6 / R9: load and store through two hops
        prog_begin();
        emit(16'h8100); emit(16'h9005); emit(16'h8200); emit(16'h9007);
        emit(16'h1005); emit(16'h6007); emit(16'h7000);
        poke(16'h0100, 16'hF300); poke(16'h0300, 16'h1234);
        poke(16'h0200, 16'h5400); poke(16'h0400, 16'h0000);
        run_prog(200);
        chk_ev("R5", 15, 1'b1, 1'b0, 16'h0100);
        chk_ev("R5", 18, 1'b1, 1'b0, 16'h0300);
        chk_ev("R5", 21, 1'b1, 1'b0, 16'h0005);
        chk_ev("R5", 24, 1'b1, 1'b0, 16'h0200);
        chk("R9", ev_at(27), -1, "no read in store cycle 7");
        chk_ev("R9", 29, 1'b0, 1'b1, 16'h0400);
        chk("R9", (ev_at(29) < 0) ? 32'hDEAD : {16'h0, ev_dat[ev_at(29)]}, 32'h1234, "store data");
        chk("R6", mem[16'h0400], 16'h1234, "loaded word stored back");
        chk("R10", halt_cyc, 33, "halt after memory ops");
        begin
            int both = 0;
            for (int i = 0; i < ev_n; i++) if (ev_rd[i] && ev_wr[i]) both++;
            chk("R12", both, 0, "cycles with both strobes");
        end

        // R3 / R11: constant load survives an undefined opcode
        for (int k = 0; k < 4; k++) begin
            prog_begin();
            emit(16'h8850); emit(16'h9006); emit({4'h8, kv[k]});
            emit(16'hC9F6); emit(16'h6006); emit(16'h7000);
            poke(16'h0850, 16'h0C00); poke(16'h0C00, 16'hBEEF);
            run_prog(200);
            chk("R3", mem[16'h0C00], {4'h0, kv[k]}, "constant load (R11 filler)");
        end

        // R4: every register index as pointer source and store pointer
        for (int i = 0; i < 16; i++) begin
            int j;
            j = (i + 1) % 16;
            prog_begin();
            emit(16'h8840); emit(16'h9000 | 16'(i)); emit(16'h8841);
            emit(16'h9000 | 16'(j)); emit(16'h1000 | 16'(i));
            emit(16'h6000 | 16'(j)); emit(16'h7000);
            poke(16'h0840, 16'h0A00 | 16'(i));
            poke(16'h0A00 | 16'(i), 16'hC000 + 16'(i) * 16'h0111);
            poke(16'h0841, 16'h0B00);
            run_prog(200);
            chk("R4", mem[16'h0B00], 16'hC000 + 16'(i) * 16'h0111,
                $sformatf("register %0d", i));
        end

        // R7 / R8: arithmetic and logic sweep
        for (int op = 2; op <= 5; op++) begin
            for (int v = 0; v < 8; v++) begin
                prog_begin();
                emit(16'h8800); emit(16'h9002); emit(16'h8801); emit(16'h9003);
                emit(16'h8802); emit(16'h9004); emit(16'h1002);
                emit(16'(op << 12) | 16'h0003); emit(16'h6004); emit(16'h7000);
                poke(16'h0800, 16'h0900); poke(16'h0801, 16'h0901);
                poke(16'h0802, 16'h0902); poke(16'h0900, va[v]);
                poke(16'h0901, vb[v]); poke(16'h0902, 16'hDEAD);
                run_prog(200);
                chk((op <= 3) ? "R7" : "R8", mem[16'h0902], alu_ref(op, va[v], vb[v]),
                    $sformatf("op %0d pair %0d", op, v));
            end
        end

        // R1: registers and accumulator cleared by reset (store via R0 to mem[0])
        prog_begin();
        emit(16'h6000); emit(16'h7000);
        run_prog(100);
        chk_ev("R1", 3, 1'b1, 1'b0, 16'h0000);
        chk_ev("R1", 8, 1'b0, 1'b1, 16'h0000);
        chk("R1", mem[16'h0000], 16'h0000, "cleared accumulator written");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule